// File: doc/BRIEF.md
# Key-Sequenced Watchdog Timer

This block is a watchdog timer that software controls through one 8-bit register on a simple synchronous write/read bus. Specific byte values act as keys. One key enables the watchdog and restarts its count. A two-byte sequence, completed within a short window of system clock cycles, turns it off. A third key permanently blocks that turn-off path until the next reset. A write with bit 7 clear programs a 3-bit interval field.

The timeout is a power of four of low-frequency clock periods. That clock reaches the block as a one-cycle tick enable in the system clock domain. When the count expires, the block pulses a reset request for one system clock cycle. A reset-generation block elsewhere consumes this pulse. The `BASE` parameter sets the smallest exponent. Its default is 3, and it must be at least 1.

Top module: `key_watchdog`

## Requirements
- R1: Writing 0xA5 enables the watchdog and clears its count to zero. If that write lands in the cycle a timeout would have occurred, no reset request follows.
- R2: A write of 0xDE followed by a write of 0xAD turns the watchdog off when the 0xAD write is at most 4 clock edges after the 0xDE write. At a gap of 5 or more, the 0xAD write does nothing.
- R3: While the first half is pending, any write other than 0xAD cancels it. A new 0xDE write restarts the window.
- R4: Writing 0xFF sets a lockout. Until the next reset, no turn-off sequence has any effect.
- R5: Writing 0xFF neither restarts the count nor enables a watchdog that is off.
- R6: While the watchdog is enabled, the count advances on each cycle with `tick` high. The timeout comes after 4^(interval+BASE) ticks, and `rst_req` goes high in the cycle after the final tick.
- R7: A write with bit 7 = 0 loads bits [2:0] into the interval. Bits [6:3] of that write are ignored.
- R8: `rd_data` returns the interval in bits [2:0], with bits [7:3] at zero.
- R9: Writes with bit 7 set that are not 0xA5, 0xDE, 0xAD or 0xFF are ignored. A 0xAD write with no pending first half is also ignored.
- R10: After reset, the watchdog is enabled, the count is zero, the interval is 7, the lockout is clear and `rst_req` is low.
- R11: `rst_req` lasts exactly one cycle. The count then restarts from zero and the next timeout follows a full interval later.
- R12: While the watchdog is off, the count stays at zero and no reset request occurs. Writing 0xA5 restarts it from zero.
- R13: Changing the interval does not clear the count. If the count already meets or exceeds the new terminal value, the timeout fires on the next tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| tick | input | 1 | One-cycle enable, one per low-frequency clock period |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write data |
| rd_data | output | 8 | Register read data (interval in bits [2:0]) |
| rst_req | output | 1 | One-cycle reset request on timeout |

## Verification
The bench sweeps every interval and measures the exact tick count to each timeout and to the one after it. A wrong exponent or an off-by-one terminal compare shows up as a wrong count.

It probes the turn-off window at gaps of 1, 4 and 5 edges. A window that is one cycle too long or too short either turns the watchdog off when it should not or leaves it running. It also puts an interval write, a junk key, or a repeated first half in the middle of the sequence. A design that fails to cancel, or fails to re-arm, changes whether the watchdog stops.

The lockout, a kick that lands in the timeout cycle, and shrinking or growing the interval while the count runs each target a specific mistake. Such a design would restart the count on 0xFF, pulse the reset request despite the restart, clear the count on an interval write, or miss a count already past the new limit.

// File: rtl/kwdt_pkg.sv
package kwdt_pkg;

  localparam logic [7:0] KEY_KICK    = 8'hA5;
  localparam logic [7:0] KEY_OFF_1ST = 8'hDE;
  localparam logic [7:0] KEY_OFF_2ND = 8'hAD;
  localparam logic [7:0] KEY_LOCK    = 8'hFF;

  typedef enum logic [2:0] {
    EV_NONE,
    EV_KICK,
    EV_ARM,
    EV_CONFIRM,
    EV_LOCK,
    EV_SETIV,
    EV_JUNK
  } wr_ev_e;

  // Number of ticks in one timeout period: 4^(iv+base).
  function automatic logic [63:0] term_ticks(input int unsigned iv,
                                             input int unsigned base);
    return 64'd1 << (2 * (iv + base));
  endfunction

  // Counter width able to hold the largest terminal value.
  function automatic int unsigned count_width(input int unsigned ivw,
                                              input int unsigned base);
    return 2 * (((1 << ivw) - 1) + base) + 1;
  endfunction

endpackage

// File: rtl/kwdt_decode.sv
module kwdt_decode
  import kwdt_pkg::*;
(
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  output wr_ev_e     ev
);

  always_comb begin
    ev = EV_NONE;
    if (wr_en) begin
      if (!wr_data[7])                  ev = EV_SETIV;
      else if (wr_data == KEY_KICK)     ev = EV_KICK;
      else if (wr_data == KEY_OFF_1ST)  ev = EV_ARM;
      else if (wr_data == KEY_OFF_2ND)  ev = EV_CONFIRM;
      else if (wr_data == KEY_LOCK)     ev = EV_LOCK;
      else                              ev = EV_JUNK;
    end
  end

endmodule

// File: rtl/kwdt_ctrl.sv
module kwdt_ctrl
  import kwdt_pkg::*;
#(
  parameter int unsigned IVW = 3,
  parameter int unsigned WIN = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  wr_ev_e         ev,
  input  logic [IVW-1:0] iv_in,
  output logic           en,
  output logic           locked,
  output logic [IVW-1:0] iv,
  output logic           restart
);

  localparam int unsigned PW = $clog2(WIN + 1);

  logic [PW-1:0] pend;
  logic          armed;
  logic          arm_ok;
  logic          off_fire;

  assign armed    = (pend != '0);
  assign arm_ok   = (ev == EV_ARM) && !locked;
  assign off_fire = (ev == EV_CONFIRM) && armed;
  assign restart  = (ev == EV_KICK);

  // Window for the second half of the turn-off sequence.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                pend <= '0;
    else if (arm_ok)           pend <= PW'(WIN);
    else if (ev != EV_NONE)    pend <= '0;
    else if (armed)            pend <= pend - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                en <= 1'b1;
    else if (off_fire)         en <= 1'b0;
    else if (ev == EV_KICK)    en <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                locked <= 1'b0;
    else if (ev == EV_LOCK)    locked <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                iv <= '1;
    else if (ev == EV_SETIV)   iv <= iv_in;
  end

  a_r1_kick_enables: assert property (@(posedge clk) disable iff (!rst_n)
    (ev == EV_KICK) |=> en);
  a_r2_off_in_window: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(en) |-> $past(pend != '0));
  a_r2_window_bound: assert property (@(posedge clk) disable iff (!rst_n)
    pend <= PW'(WIN));
  a_r4_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> locked);
  a_r4_locked_stays_on: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && en) |=> en);
  a_r5_lock_no_enable: assert property (@(posedge clk) disable iff (!rst_n)
    ((ev == EV_LOCK) && !en) |=> !en);

endmodule

// File: rtl/kwdt_count.sv
module kwdt_count
  import kwdt_pkg::*;
#(
  parameter int unsigned IVW  = 3,
  parameter int unsigned BASE = 3,
  parameter int unsigned CW   = 21
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           tick,
  input  logic           en,
  input  logic           restart,
  input  logic [IVW-1:0] iv,
  output logic [CW-1:0]  cnt,
  output logic           rst_req
);

  logic [CW-1:0] term;
  logic [CW-1:0] cnt_inc;
  logic          fire;

  assign term    = CW'(term_ticks(32'(iv), BASE));
  assign cnt_inc = cnt + 1'b1;
  assign fire    = en && tick && !restart && (cnt_inc >= term);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt <= '0;
    else if (restart || !en)   cnt <= '0;
    else if (tick)             cnt <= fire ? '0 : cnt_inc;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_req <= 1'b0;
    else        rst_req <= fire;
  end

  a_r11_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> !rst_req);
  a_r12_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (cnt == '0 && !rst_req));
  a_r1_restart_clears: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (cnt == '0 && !rst_req));
  a_r6_fire_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> $past(tick && en));
  a_r13_over_fires: assert property (@(posedge clk) disable iff (!rst_n)
    (en && tick && !restart && cnt >= term) |=> rst_req);

endmodule

// File: rtl/key_watchdog.sv
module key_watchdog
  import kwdt_pkg::*;
#(
  parameter int unsigned IVW  = 3,
  parameter int unsigned WIN  = 4,
  parameter int unsigned BASE = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  output logic [7:0] rd_data,
  output logic       rst_req
);

  localparam int unsigned CW = count_width(IVW, BASE);

  wr_ev_e         ev;
  logic           en;
  logic           locked;
  logic [IVW-1:0] iv;
  logic           restart;
  logic [CW-1:0]  cnt;

  kwdt_decode u_dec (
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .ev      (ev)
  );

  kwdt_ctrl #(.IVW(IVW), .WIN(WIN)) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .ev      (ev),
    .iv_in   (wr_data[IVW-1:0]),
    .en      (en),
    .locked  (locked),
    .iv      (iv),
    .restart (restart)
  );

  kwdt_count #(.IVW(IVW), .BASE(BASE), .CW(CW)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick),
    .en      (en),
    .restart (restart),
    .iv      (iv),
    .cnt     (cnt),
    .rst_req (rst_req)
  );

  assign rd_data = 8'(iv);

  a_r8_read_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[7:IVW] == '0);

endmodule

// File: tb/key_watchdog_test.sv
module key_watchdog_test;

  localparam int BASE = 1;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b1;
  logic       tick_alt = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic       rst_req;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  bit done = 0;

  key_watchdog #(.IVW(3), .WIN(4), .BASE(BASE)) uut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en),
    .wr_data(wr_data), .rd_data(rd_data), .rst_req(rst_req)
  );

  always #5 clk = ~clk;

  always @(negedge clk) tick <= tick_alt ? ~tick : 1'b1;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 190000 && !done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired: actual hung, expected finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  function automatic int period(int iv);
    return 1 << (2 * (iv + BASE));
  endfunction

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Called at a negedge; returns at the negedge after the write edge.
  task automatic wr(logic [7:0] d);
    wr_en = 1'b1; wr_data = d;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0; wr_data = 8'h00;
  endtask

  task automatic idle(int k);
    repeat (k) @(negedge clk);
  endtask

  task automatic wait_fire(output int n);
    n = 0;
    while (1) begin
      @(posedge clk); n++;
      @(negedge clk);
      if (rst_req) break;
      if (n > 70000) begin n = -1; break; end
    end
  endtask

  task automatic pulses(int k, output int hits);
    hits = 0;
    repeat (k) begin
      @(negedge clk);
      if (rst_req) hits++;
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    idle(2);
    rst_n = 1'b1;
  endtask

  initial begin
    int n, h;
    idle(2);
    rst_n = 1'b1;
    // R10 reset state
    check("R10 rst_req after reset", int'(rst_req), 0);
    check("R10/R8 read after reset", int'(rd_data), 7);
    wait_fire(n);
    check("R10/R6 default timeout", n, period(7));

    // R6/R7/R8/R11 interval sweep
    for (int iv = 0; iv < 7; iv++) begin
      wr({1'b0, 4'(iv * 3 + 5), 3'(iv)});
      check("R8/R7 read interval", int'(rd_data), iv);
      wr(8'hA5);
      wait_fire(n);
      check("R6 timeout ticks", n, period(iv));
      @(negedge clk);
      check("R11 pulse one cycle", int'(rst_req), 0);
      wait_fire(n);
      check("R11 next timeout", n, period(iv) - 1);
    end

    // R1 kick in the timeout cycle suppresses the request
    wr(8'h00); wr(8'hA5);
    idle(3);
    wr(8'hA5);
    check("R1 no request on kick cycle", int'(rst_req), 0);
    wait_fire(n);
    check("R1 restart from zero", n, period(0));
    wr(8'h01); wr(8'hA5);
    idle(9);
    wr(8'hA5);
    wait_fire(n);
    check("R1 mid-run kick", n, period(1));

    // R2 window edges
    wr(8'h00); wr(8'hA5);
    wr(8'hDE); idle(3); wr(8'hAD);
    pulses(60, h);
    check("R2 gap 4 turns off", h, 0);
    check("R12 count held, no requests", h, 0);
    wr(8'hA5);
    wait_fire(n);
    check("R12 re-enable from zero", n, period(0));
    wr(8'hDE); idle(4); wr(8'hAD);
    pulses(60, h);
    check("R2 gap 5 ignored", int'(h > 0), 1);
    wr(8'hDE); wr(8'hAD);
    pulses(60, h);
    check("R2 back-to-back turns off", h, 0);
    wr(8'hA5);

    // R3 cancellation and re-arm
    wr(8'hDE); wr(8'h01); wr(8'hAD);
    check("R3/R7 interval write in sequence", int'(rd_data), 1);
    pulses(60, h);
    check("R3 interval write cancels", int'(h > 0), 1);
    wr(8'h00);
    wr(8'hDE); wr(8'h80); wr(8'hAD);
    pulses(60, h);
    check("R3 junk write cancels", int'(h > 0), 1);
    wr(8'hDE); wr(8'hDE); idle(3); wr(8'hAD);
    pulses(60, h);
    check("R3 second DE restarts window", h, 0);
    wr(8'hA5);

    // R9 junk and lone AD
    wr(8'hA5);
    idle(1);
    wr(8'hC3);
    check("R9 junk leaves interval", int'(rd_data), 0);
    wait_fire(n);
    check("R9 junk no restart", n, period(0) - 2);
    wr(8'hAD);
    pulses(60, h);
    check("R9 lone AD ignored", int'(h > 0), 1);

    // R5 lockout does not restart
    wr(8'h01); wr(8'hA5);
    idle(5);
    wr(8'hFF);
    wait_fire(n);
    check("R5 lock keeps count", n, period(1) - 6);
    // R4 turn-off blocked
    wr(8'h00);
    wr(8'hDE); wr(8'hAD);
    pulses(60, h);
    check("R4 locked turn-off ignored", int'(h > 0), 1);

    // R10 reset clears lockout; R5 lock does not enable when off
    do_reset();
    check("R10 read after second reset", int'(rd_data), 7);
    wr(8'hDE); wr(8'hAD);
    wr(8'h00);
    wr(8'hFF);
    pulses(60, h);
    check("R10/R5 off stays off after lock", h, 0);
    wr(8'hDE); wr(8'hAD);
    wr(8'hA5);
    wait_fire(n);
    check("R4 locked, kick runs", n, period(0));

    // R13 interval changes while running
    wr(8'h02); wr(8'hA5);
    idle(29);
    wr(8'h01);
    wait_fire(n);
    check("R13 shrink past count", n, 1);
    wr(8'h01); wr(8'hA5);
    idle(9);
    wr(8'h02);
    wait_fire(n);
    check("R13 grow keeps count", n, period(2) - 10);

    // R6 only ticks advance the count
    tick_alt = 1'b1;
    wr(8'h00); wr(8'hA5);
    wait_fire(n);
    check("R6 half-rate ticks", int'(n == 7 || n == 8), 1);
    tick_alt = 1'b0;

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule